// File: doc/BRIEF.md
# Fixed-Point Spiking Neuron Core

This block holds the state of one spiking neuron of the quadratic integrate-and-fire family with an adaptation variable. Both state words, the membrane voltage and the adaptive value, are signed fixed point of `N` bits, of which `Q` are fractional. Every model constant and input uses the same format. On each rising clock edge where `apply` is high, the block performs one explicit Euler step. The voltage change and the adaptive change are computed combinationally from the present state and added to the registers in that one cycle. The time-step input is supplied already divided by the membrane time constant.

When the voltage present at an applying edge is at or above the threshold input, the block does not integrate. The voltage is loaded with the constant `c`, the constant `d` is added to the adaptive value, and a registered spike flag is raised for the following cycle. A synchronous active-high reset reloads both state words from their initial-value inputs. The block is meant to be instantiated once per neuron by a surrounding network that supplies currents and collects spikes.

Top module: `izh_neuron_core`

## Requirements
- R1: While `rst` is high at a rising edge, `voltage` takes `v_init`, `adapt` takes `w_init` and `spike` goes to 0.
- R2: At a rising edge with `rst` low and `apply` low, `voltage` and `adapt` keep their values and `spike` goes to 0.
- R3: At an applying edge with `voltage < v_th` (signed), `voltage` becomes `voltage + fmul(step, fmul(K1, fmul(voltage,voltage)) + fmul(K5, voltage) + K140 - adapt + i_cur)`. Here K1 = round(0.04·2^Q) (2621 at Q=16), K5 = 5·2^Q and K140 = 140·2^Q, and the sums wrap modulo 2^N.
- R4: At the same kind of edge, `adapt` becomes `adapt + fmul(step, fmul(a, fmul(b, voltage) - adapt))`, with the sums wrapping modulo 2^N.
- R5: At an applying edge with `voltage >= v_th` (signed), `voltage` becomes `c` and `adapt` becomes `adapt + d`. No integration takes place at that edge.
- R6: `spike` is 1 for exactly the clock cycle that follows an applying edge at which R5 fired. It is 0 after every other edge.
- R7: `fmul(x,y)` is the signed 2N-bit product shifted arithmetically right by Q, keeping the low N bits. The result is floored toward negative infinity and wraps on overflow.
- R8: A voltage exactly equal to `v_th` fires, following R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to initial values |
| apply | input | 1 | Perform one update step at this edge |
| i_cur | input | N | Input current, signed Q format |
| v_init | input | N | Voltage loaded by reset |
| w_init | input | N | Adaptive value loaded by reset |
| v_th | input | N | Firing threshold |
| step | input | N | Time step divided by membrane time constant |
| a | input | N | Adaptation rate constant |
| b | input | N | Adaptation sensitivity constant |
| c | input | N | Voltage after a spike |
| d | input | N | Adaptive increment after a spike |
| voltage | output | N | Membrane voltage state |
| adapt | output | N | Adaptive value state |
| spike | output | 1 | Registered one-cycle spike flag |

## Verification
The firing reset and the spike flag of the previous step can meet in one cycle. When `c` is not below `v_th`, the neuron fires on consecutive applying edges, so `spike` stays high while `voltage` is reloaded with `c` again. The bench provokes this with a low threshold, and it also lands a reset in the cycle right after a firing edge. Each cycle is judged against an integer model of the same floor-and-wrap arithmetic. That model predicts `voltage`, `adapt` and `spike` independently, over long runs of pseudo-random currents and `apply` patterns.

// File: rtl/izh_pkg.sv
package izh_pkg;
  // Rounded num/den scaled by 2^q, used to build Q-format constants.
  function automatic longint fx_ratio(input longint num, input longint den, input int q);
    longint scaled;
    scaled = num <<< q;
    return (scaled + den / 2) / den;
  endfunction
endpackage

// File: rtl/izh_fx_mul.sv
module izh_fx_mul #(
  parameter int N = 32,
  parameter int Q = 16
) (
  input  logic signed [N-1:0] x,
  input  logic signed [N-1:0] y,
  output logic signed [N-1:0] p
);
  localparam int PW = 2 * N;
  logic signed [PW-1:0] full;
  logic unused_mul_bits;

  assign full = x * y;
  // Keeping bits [Q+N-1:Q] is an arithmetic shift by Q with floor, then wrap.
  assign p = full[Q +: N];
  assign unused_mul_bits = ^{full[PW-1:Q+N], full[Q-1:0]};
endmodule

// File: rtl/izh_dv_calc.sv
module izh_dv_calc #(
  parameter int N = 32,
  parameter int Q = 16
) (
  input  logic signed [N-1:0] v,
  input  logic signed [N-1:0] w,
  input  logic signed [N-1:0] i_cur,
  input  logic signed [N-1:0] step,
  output logic signed [N-1:0] dv
);
  localparam logic signed [N-1:0] K_QUAD = N'(izh_pkg::fx_ratio(4, 100, Q));
  localparam logic signed [N-1:0] K_LIN  = N'(longint'(5) <<< Q);
  localparam logic signed [N-1:0] K_OFF  = N'(longint'(140) <<< Q);

  logic signed [N-1:0] v_sq, quad_t, lin_t, drive;

  izh_fx_mul #(.N(N), .Q(Q)) u_sq   (.x(v),      .y(v),     .p(v_sq));
  izh_fx_mul #(.N(N), .Q(Q)) u_quad (.x(K_QUAD), .y(v_sq),  .p(quad_t));
  izh_fx_mul #(.N(N), .Q(Q)) u_lin  (.x(K_LIN),  .y(v),     .p(lin_t));

  assign drive = quad_t + lin_t + K_OFF - w + i_cur;

  izh_fx_mul #(.N(N), .Q(Q)) u_step (.x(step), .y(drive), .p(dv));
endmodule

// File: rtl/izh_dw_calc.sv
module izh_dw_calc #(
  parameter int N = 32,
  parameter int Q = 16
) (
  input  logic signed [N-1:0] v,
  input  logic signed [N-1:0] w,
  input  logic signed [N-1:0] a,
  input  logic signed [N-1:0] b,
  input  logic signed [N-1:0] step,
  output logic signed [N-1:0] dw
);
  logic signed [N-1:0] bv, gap, rate;

  izh_fx_mul #(.N(N), .Q(Q)) u_bv (.x(b), .y(v), .p(bv));
  assign gap = bv - w;
  izh_fx_mul #(.N(N), .Q(Q)) u_rate (.x(a),    .y(gap),  .p(rate));
  izh_fx_mul #(.N(N), .Q(Q)) u_step (.x(step), .y(rate), .p(dw));
endmodule

// File: rtl/izh_neuron_core.sv
module izh_neuron_core #(
  parameter int N = 32,
  parameter int Q = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                apply,
  input  logic signed [N-1:0] i_cur,
  input  logic signed [N-1:0] v_init,
  input  logic signed [N-1:0] w_init,
  input  logic signed [N-1:0] v_th,
  input  logic signed [N-1:0] step,
  input  logic signed [N-1:0] a,
  input  logic signed [N-1:0] b,
  input  logic signed [N-1:0] c,
  input  logic signed [N-1:0] d,
  output logic signed [N-1:0] voltage,
  output logic signed [N-1:0] adapt,
  output logic                spike
);
  logic signed [N-1:0] dv, dw;
  logic fire;

  izh_dv_calc #(.N(N), .Q(Q)) u_dv (
    .v(voltage), .w(adapt), .i_cur(i_cur), .step(step), .dv(dv));
  izh_dw_calc #(.N(N), .Q(Q)) u_dw (
    .v(voltage), .w(adapt), .a(a), .b(b), .step(step), .dw(dw));

  assign fire = (voltage >= v_th);

  always_ff @(posedge clk) begin
    if (rst) begin
      voltage <= v_init;
      adapt   <= w_init;
      spike   <= 1'b0;
    end else if (apply) begin
      spike <= fire;
      if (fire) begin
        voltage <= c;
        adapt   <= adapt + d;
      end else begin
        voltage <= voltage + dv;
        adapt   <= adapt + dw;
      end
    end else begin
      spike <= 1'b0;
    end
  end

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(voltage) && $stable(adapt) && !spike);

  // R5
  fire_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (apply && voltage >= v_th) |=> (voltage == $past(c)) && (adapt == $past(adapt + d)));

  // R6
  spike_after_apply_chk: assert property (@(posedge clk) disable iff (rst)
    spike |-> $past(apply));

  // R6
  spike_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (apply && voltage >= v_th) |=> spike);

  // R6
  no_spike_below_chk: assert property (@(posedge clk) disable iff (rst)
    (apply && voltage < v_th) |=> !spike);
endmodule

// File: tb/tb_izh_neuron_core.sv
module tb_izh_neuron_core;
  localparam int N = 32;
  localparam int Q = 16;
  localparam int CLK_PERIOD = 10;
  localparam int K1 = 2621;
  localparam int ONE = 1 << Q;

  logic clk = 1'b0;
  logic rst, apply;
  logic signed [N-1:0] i_cur, v_init, w_init, v_th, step, a, b, c, d;
  logic signed [N-1:0] voltage, adapt;
  logic spike;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int mv, mw;
  bit ms;

  always #(CLK_PERIOD / 2) clk = ~clk;

  izh_neuron_core #(.N(N), .Q(Q)) dut (
    .clk(clk), .rst(rst), .apply(apply), .i_cur(i_cur), .v_init(v_init),
    .w_init(w_init), .v_th(v_th), .step(step), .a(a), .b(b), .c(c), .d(d),
    .voltage(voltage), .adapt(adapt), .spike(spike));

  // R7: floor shift of the full signed product, low word kept
  function automatic int fmul(input int x, input int y);
    longint p;
    p = longint'(x) * longint'(y);
    return int'(p >>> Q);
  endfunction

  function automatic int lcg(input int s);
    return s * 1103515245 + 12345;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One edge: inputs already driven; advance model, then compare after the edge.
  task automatic tick(input string tag);
    int nv, nw;
    bit ns;
    nv = mv; nw = mw; ns = 0;
    if (rst) begin
      nv = v_init; nw = w_init; ns = 0;
    end else if (apply) begin
      if (mv >= int'(v_th)) begin
        nv = c; nw = mw + d; ns = 1;
      end else begin
        int drive;
        drive = fmul(K1, fmul(mv, mv)) + fmul(5 * ONE, mv) + 140 * ONE - mw + i_cur;
        nv = mv + fmul(step, drive);
        nw = mw + fmul(step, fmul(a, fmul(b, mv) - mw));
      end
    end
    @(negedge clk);
    mv = nv; mw = nw; ms = ns;
    check(tag, "voltage", voltage, mv);
    check(tag, "adapt", adapt, mw);
    check(ns ? "R6" : tag, "spike", int'(spike), int'(ms));
  endtask

  task automatic set_params(input int th, input int st, input int pa, input int pb,
                            input int pc, input int pd);
    v_th = th; step = st; a = pa; b = pb; c = pc; d = pd;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    mv = 0; mw = 0; ms = 0;
    rst = 1; apply = 0; i_cur = 0;
    v_init = -65 * ONE; w_init = -13 * ONE;
    set_params(30 * ONE, ONE / 4, 1311, 13107, -65 * ONE, 8 * ONE);
    @(negedge clk);
    tick("R1");
    rst = 0;

    // R2: idle edges hold state
    for (int k = 0; k < 4; k++) tick("R2");

    // R3 R4: steady drive with regular-spiking constants
    apply = 1; i_cur = 10 * ONE;
    for (int k = 0; k < 400; k++) tick("R3");

    // R8: voltage exactly at threshold fires
    rst = 1; apply = 0; v_init = 30 * ONE; w_init = 2 * ONE;
    tick("R1");
    rst = 0; apply = 1;
    tick("R8");
    apply = 0;
    tick("R2");

    // R7: negative and odd-fraction values exercise floor rounding
    rst = 1; v_init = -1; w_init = -3;
    set_params(30 * ONE, ONE, 3, -5, -65 * ONE, 8 * ONE);
    tick("R1");
    rst = 0; apply = 1; i_cur = -7;
    for (int k = 0; k < 3; k++) tick("R7");

    // R5 R6: c above threshold fires on consecutive edges, then reset right after a fire
    rst = 1; apply = 0; v_init = 0; w_init = 0;
    set_params(-10 * ONE, ONE / 8, 1311, 13107, -5 * ONE, 3 * ONE);
    tick("R1");
    rst = 0; apply = 1;
    for (int k = 0; k < 4; k++) tick("R5");
    rst = 1;
    tick("R1");
    rst = 0;

    // R4 R5 R6: pseudo-random sweeps over several constant sets
    seed = 7;
    for (int set = 0; set < 4; set++) begin
      case (set)
        0: set_params(30 * ONE, ONE / 4, 1311, 13107, -65 * ONE, 8 * ONE);
        1: set_params(30 * ONE, ONE / 2, 6554, 13107, -65 * ONE, 2 * ONE);
        2: set_params(30 * ONE, ONE / 4, 1311, 16384, -50 * ONE, 2 * ONE);
        default: set_params(25 * ONE, ONE / 8, 6554, 16384, -55 * ONE, 4 * ONE);
      endcase
      rst = 1; apply = 0; v_init = -65 * ONE; w_init = -10 * ONE;
      tick("R1");
      rst = 0;
      for (int k = 0; k < 3000; k++) begin
        seed = lcg(seed);
        apply = ((seed >>> 20) & 3) != 0;
        i_cur = ((seed >>> 8) & 32'h1F_FFFF) - (4 * ONE);
        rst = (((seed >>> 4) & 1023) == 5);
        tick(rst ? "R1" : (apply ? "R4" : "R2"));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule